// File: doc/BRIEF.md
# Autonomous Profile Sequencer

The sequencer generates read addresses for a shared waveform memory that is split into four segments, called profiles. Each profile is described by a start address, a final address and a recirculate bit. A 3-bit control code selects the sequencing behaviour:

- Chained sequencing runs profiles in order from 0. It can run once (single burst) or wrap back to profile 0 for as long as the code stays in force.
- Manual mode takes the profile from external select pins.

The code is captured on an update strobe. The strobe also starts, or restarts, the sweep.

In chained sequencing every segment is swept upward by one address per clock-enable cycle. When the address reaches the current profile's final address, the block moves on to the next profile. When the last profile of a single burst finishes, the block raises a done flag and holds the address. In manual mode the recirculate bit of the selected profile chooses between holding at the final address and jumping back to the start address. The memory contents and the waveform synthesis that uses the addresses are not part of this block.

Top module: `profile_sequencer`

## Requirements
- R1: After reset the profile index is 0, the address is 0, and valid, done and the error flag are all low. Nothing moves until the first update strobe.
- R2: On the cycle after an update strobe with a chained code (001 to 110), the block latches the code. It shows profile 0 at profile 0's start address, with valid high and done low.
- R3: While valid and not at the current final address, each cycle with clock enable high advances the address by one. A cycle with clock enable low and no strobe changes no output.
- R4: In chained sequencing, an enabled cycle at the current final address (when this is not the last profile) moves to profile index + 1 at that profile's start address.
- R5: Single-burst codes 001, 010 and 011 end after profile 1, 2 and 3 respectively. On the enabled cycle at that final address, done rises and valid falls, and the address and profile hold until the next strobe.
- R6: Continuous codes 100, 101 and 110 treat profile 1, 2 and 3 respectively as last. From its final address they go to profile 0's start address and never raise done.
- R7: In chained sequencing the per-profile recirculate bits have no effect: a segment is never swept again in place.
- R8: With code 000, a strobe loads the profile given by the external select pins. On an enabled cycle, a change on those pins loads the new profile's start address. At the final address, recirculate bit 0 holds the address and bit 1 reloads the start address.
- R9: Code 111 is handled exactly like 000. The error flag is high from the cycle after that strobe until the cycle after the next strobe with another code.
- R10: A strobe takes effect even while clock enable is low. A strobe during a sweep abandons it and starts again under the newly latched code.
- R11: A strobe after a completed burst clears done and runs the burst again from profile 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_code | input | 3 | Sequencing code, captured on the update strobe |
| upd_stb | input | 1 | Update strobe: latch code and start a sweep |
| clk_en | input | 1 | Advance enable for the address generator |
| ext_prof | input | 2 | External profile select used in manual mode |
| seg_start | input | 4*ADDR_W | Start addresses, profile p at bits [p*ADDR_W +: ADDR_W] |
| seg_final | input | 4*ADDR_W | Final addresses, same packing |
| seg_recirc | input | 4 | Recirculate bit per profile, bit p for profile p |
| prof_idx | output | 2 | Current profile index |
| ram_addr | output | ADDR_W | Waveform memory address |
| addr_valid | output | 1 | Address is part of an active sweep |
| burst_done | output | 1 | Single burst finished |
| code_err | output | 1 | Latched code was the invalid value 111 |

## Verification
The bench covers the following cases, and what a faulty design would do in each:

- A profile one address long, where start equals final. A design that advances before comparing would overrun into the next segment.
- The last-profile decision for every code. An off-by-one in the last index would stop a burst one profile early, or wrap a continuous run too late.
- A strobe issued with clock enable low in the middle of a sweep, and a strobe issued after done. A design that gates the strobe with the enable, or forgets to clear done, would stay stuck.
- Manual mode with changing select pins and both settings of the recirculate bit, with the recirculate bits set in chained mode too. A design that consults them there would loop inside one segment.

// File: rtl/pseq_pkg.sv
// Package: shared constants and code-decoding helpers for the profile sequencer.
// Assumes a fixed set of four profiles addressed by a 2-bit index.
package pseq_pkg;

    localparam int PROF_N = 4;
    localparam int PROF_W = 2;

    localparam logic [2:0] CODE_MANUAL  = 3'b000;
    localparam logic [2:0] CODE_INVALID = 3'b111;

    // True when the code selects chained (internal) sequencing.
    function automatic logic code_chained(input logic [2:0] code);
        return (code != CODE_MANUAL) && (code != CODE_INVALID);
    endfunction

    // Index of the last profile in the chain for a chained code.
    function automatic logic [PROF_W-1:0] code_last(input logic [2:0] code);
        return code[2] ? (code[1:0] + 2'd1) : code[1:0];
    endfunction

endpackage

// File: rtl/pseq_decode.sv
// Module: turns a 3-bit sequencing code into control terms.
// Assumes the code is already registered or stable for the cycle it is used in.
module pseq_decode
    import pseq_pkg::*;
(
    input  logic [2:0]        code,
    output logic              chained,
    output logic              looping,
    output logic              bad,
    output logic [PROF_W-1:0] last_idx
);

    // Pure decode of the code field.
    always_comb begin
        chained  = code_chained(code);
        bad      = (code == CODE_INVALID);
        looping  = chained && code[2];
        last_idx = chained ? code_last(code) : '0;
    end

endmodule

// File: rtl/pseq_seg_mux.sv
// Module: selects one profile's segment descriptor out of the packed tables.
// Assumes tables pack profile p at [p*ADDR_W +: ADDR_W] and recirc bit p.
module pseq_seg_mux
    import pseq_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic [PROF_N*ADDR_W-1:0] starts,
    input  logic [PROF_N*ADDR_W-1:0] finals,
    input  logic [PROF_N-1:0]        recircs,
    input  logic [PROF_W-1:0]        sel,
    output logic [ADDR_W-1:0]        start_o,
    output logic [ADDR_W-1:0]        final_o,
    output logic                     recirc_o
);

    logic [ADDR_W-1:0] start_arr [PROF_N];
    logic [ADDR_W-1:0] final_arr [PROF_N];

    genvar g;
    generate
        for (g = 0; g < PROF_N; g++) begin : g_unpack
            assign start_arr[g] = starts[g*ADDR_W +: ADDR_W];
            assign final_arr[g] = finals[g*ADDR_W +: ADDR_W];
        end
    endgenerate

    // Index into the unpacked descriptor arrays.
    always_comb begin
        start_o  = start_arr[sel];
        final_o  = final_arr[sel];
        recirc_o = recircs[sel];
    end

endmodule

// File: rtl/pseq_ctrl.sv
// Module: state registers and next-state logic of the sequencer.
// Assumes start <= final for every profile. The strobe has priority over the enable.
// The start address of the profile being loaded is supplied from outside via load_idx.
module pseq_ctrl
    import pseq_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        ctrl_code,
    input  logic              upd_stb,
    input  logic              clk_en,
    input  logic [PROF_W-1:0] ext_prof,
    input  logic              new_chained,
    input  logic              new_bad,
    input  logic              cur_chained,
    input  logic              cur_looping,
    input  logic [PROF_W-1:0] cur_last,
    input  logic [ADDR_W-1:0] cur_final,
    input  logic              cur_recirc,
    input  logic [ADDR_W-1:0] load_start,
    output logic [PROF_W-1:0] load_idx,
    output logic [2:0]        code_q,
    output logic [PROF_W-1:0] prof_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic              valid_q,
    output logic              done_q,
    output logic              err_q
);

    logic [2:0]        code_n;
    logic [PROF_W-1:0] prof_n;
    logic [ADDR_W-1:0] addr_n;
    logic              valid_n;
    logic              done_n;
    logic              err_n;
    logic              load;
    logic              at_final;

    assign at_final = (addr_q == cur_final);

    // Next-state selection: strobe, then chained stepping, then manual stepping.
    always_comb begin
        code_n   = code_q;
        prof_n   = prof_q;
        addr_n   = addr_q;
        valid_n  = valid_q;
        done_n   = done_q;
        err_n    = err_q;
        load     = 1'b0;
        load_idx = prof_q;
        if (upd_stb) begin
            code_n   = ctrl_code;
            valid_n  = 1'b1;
            done_n   = 1'b0;
            err_n    = new_bad;
            load     = 1'b1;
            load_idx = new_chained ? '0 : ext_prof;
        end else if (clk_en && valid_q) begin
            if (cur_chained) begin
                if (!at_final) begin
                    addr_n = addr_q + 1'b1;
                end else if (prof_q != cur_last) begin
                    load     = 1'b1;
                    load_idx = prof_q + 1'b1;
                end else if (cur_looping) begin
                    load     = 1'b1;
                    load_idx = '0;
                end else begin
                    valid_n = 1'b0;
                    done_n  = 1'b1;
                end
            end else begin
                if (ext_prof != prof_q) begin
                    load     = 1'b1;
                    load_idx = ext_prof;
                end else if (!at_final) begin
                    addr_n = addr_q + 1'b1;
                end else if (cur_recirc) begin
                    load     = 1'b1;
                    load_idx = prof_q;
                end
            end
        end
        if (load) begin
            prof_n = load_idx;
            addr_n = load_start;
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q  <= CODE_MANUAL;
            prof_q  <= '0;
            addr_q  <= '0;
            valid_q <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            code_q  <= code_n;
            prof_q  <= prof_n;
            addr_q  <= addr_n;
            valid_q <= valid_n;
            done_q  <= done_n;
            err_q   <= err_n;
        end
    end

endmodule

// File: rtl/profile_sequencer.sv
// Module: top of the autonomous profile sequencer.
// Decodes the live and the latched code, selects segment descriptors and runs the control FSM.
// Assumes all inputs are synchronous to clk.
module profile_sequencer
    import pseq_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2:0]               ctrl_code,
    input  logic                     upd_stb,
    input  logic                     clk_en,
    input  logic [1:0]               ext_prof,
    input  logic [4*ADDR_W-1:0]      seg_start,
    input  logic [4*ADDR_W-1:0]      seg_final,
    input  logic [3:0]               seg_recirc,
    output logic [1:0]               prof_idx,
    output logic [ADDR_W-1:0]        ram_addr,
    output logic                     addr_valid,
    output logic                     burst_done,
    output logic                     code_err
);

    logic [2:0]        code_q;
    logic [PROF_W-1:0] prof_q;
    logic [PROF_W-1:0] load_idx;
    logic [ADDR_W-1:0] addr_q;
    logic              valid_q, done_q, err_q;
    logic              dec_chained [2];
    logic              dec_looping [2];
    logic              dec_bad     [2];
    logic [PROF_W-1:0] dec_last    [2];
    logic [2:0]        dec_code    [2];
    logic [ADDR_W-1:0] cur_start, cur_final, load_start, load_final;
    logic              cur_recirc, load_recirc;

    assign dec_code[0] = code_q;
    assign dec_code[1] = ctrl_code;

    genvar d;
    generate
        for (d = 0; d < 2; d++) begin : g_dec
            pseq_decode u_dec (
                .code     (dec_code[d]),
                .chained  (dec_chained[d]),
                .looping  (dec_looping[d]),
                .bad      (dec_bad[d]),
                .last_idx (dec_last[d])
            );
        end
    endgenerate

    pseq_seg_mux #(.ADDR_W(ADDR_W)) u_cur_mux (
        .starts   (seg_start),
        .finals   (seg_final),
        .recircs  (seg_recirc),
        .sel      (prof_q),
        .start_o  (cur_start),
        .final_o  (cur_final),
        .recirc_o (cur_recirc)
    );

    pseq_seg_mux #(.ADDR_W(ADDR_W)) u_load_mux (
        .starts   (seg_start),
        .finals   (seg_final),
        .recircs  (seg_recirc),
        .sel      (load_idx),
        .start_o  (load_start),
        .final_o  (load_final),
        .recirc_o (load_recirc)
    );

    pseq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_code   (ctrl_code),
        .upd_stb     (upd_stb),
        .clk_en      (clk_en),
        .ext_prof    (ext_prof),
        .new_chained (dec_chained[1]),
        .new_bad     (dec_bad[1]),
        .cur_chained (dec_chained[0]),
        .cur_looping (dec_looping[0]),
        .cur_last    (dec_last[0]),
        .cur_final   (cur_final),
        .cur_recirc  (cur_recirc),
        .load_start  (load_start),
        .load_idx    (load_idx),
        .code_q      (code_q),
        .prof_q      (prof_q),
        .addr_q      (addr_q),
        .valid_q     (valid_q),
        .done_q      (done_q),
        .err_q       (err_q)
    );

    // Output mapping from the control registers.
    always_comb begin
        prof_idx   = prof_q;
        ram_addr   = addr_q;
        addr_valid = valid_q;
        burst_done = done_q;
        code_err   = err_q;
    end

    // Values only consumed by the bound checker or unused by design choice.
    logic unused_ok;
    assign unused_ok = ^{cur_start, load_final, load_recirc, dec_looping[1], dec_last[1], dec_bad[0]};

endmodule

// File: rtl/pseq_checker.sv
// Module: temporal assertions on the profile sequencer ports, bound to the top.
// Assumes the same packing of the segment tables as the top module.
module pseq_checker #(
    parameter int ADDR_W = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2:0]          ctrl_code,
    input logic                upd_stb,
    input logic                clk_en,
    input logic [1:0]          ext_prof,
    input logic [4*ADDR_W-1:0] seg_start,
    input logic [4*ADDR_W-1:0] seg_final,
    input logic [1:0]          prof_idx,
    input logic [ADDR_W-1:0]   ram_addr,
    input logic                addr_valid,
    input logic                burst_done,
    input logic                code_err
);

    logic [ADDR_W-1:0] chk_final;
    logic              chk_chained_in;
    logic              unused_chk;

    assign chk_final      = seg_final[prof_idx*ADDR_W +: ADDR_W];
    assign chk_chained_in = (ctrl_code != 3'b000) && (ctrl_code != 3'b111);
    assign unused_chk     = ^seg_start;

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !addr_valid && !burst_done && !code_err); // R1
    AST_STB_PROF0: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_stb && chk_chained_in) |=> (prof_idx == 2'd0) && addr_valid && !burst_done); // R2
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && clk_en && !upd_stb && ext_prof == prof_idx && ram_addr != chk_final)
        |=> ram_addr == ADDR_W'($past(ram_addr) + 1'b1)); // R3
    AST_FREEZE_NOEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && !upd_stb) |=> $stable(ram_addr) && $stable(prof_idx) && $stable(burst_done)); // R3
    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) burst_done |-> !addr_valid); // R5
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_done && !upd_stb) |=> burst_done && $stable(ram_addr) && $stable(prof_idx)); // R5
    AST_ERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb |=> code_err == ($past(ctrl_code) == 3'b111)); // R9
    AST_STB_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb |=> addr_valid && !burst_done); // R10

endmodule

bind profile_sequencer pseq_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_code  (ctrl_code),
    .upd_stb    (upd_stb),
    .clk_en     (clk_en),
    .ext_prof   (ext_prof),
    .seg_start  (seg_start),
    .seg_final  (seg_final),
    .prof_idx   (prof_idx),
    .ram_addr   (ram_addr),
    .addr_valid (addr_valid),
    .burst_done (burst_done),
    .code_err   (code_err)
);

// File: tb/profile_sequencer_test.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random stimulus against a bench-side model.
module profile_sequencer_test;

    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    code = 3'b000;
    logic          stb = 1'b0;
    logic          en = 1'b0;
    logic [1:0]    ext = 2'd0;
    logic [AW-1:0] st [4];
    logic [AW-1:0] fn [4];
    logic [3:0]    rc = 4'b0000;
    logic [4*AW-1:0] st_pk, fn_pk;

    logic [1:0]    prof_idx;
    logic [AW-1:0] ram_addr;
    logic          addr_valid, burst_done, code_err;

    int checks = 0;
    int errors = 0;

    // Model state.
    logic [2:0]    m_code = 3'b000;
    logic [1:0]    m_prof = 2'd0;
    logic [AW-1:0] m_addr = '0;
    logic          m_valid = 1'b0, m_done = 1'b0, m_err = 1'b0;

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 4; i++) begin
            st_pk[i*AW +: AW] = st[i];
            fn_pk[i*AW +: AW] = fn[i];
        end
    end

    profile_sequencer #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .ctrl_code(code), .upd_stb(stb), .clk_en(en),
        .ext_prof(ext), .seg_start(st_pk), .seg_final(fn_pk), .seg_recirc(rc),
        .prof_idx(prof_idx), .ram_addr(ram_addr), .addr_valid(addr_valid),
        .burst_done(burst_done), .code_err(code_err)
    );

    function automatic logic chained(input logic [2:0] c);
        return c != 3'b000 && c != 3'b111;
    endfunction

    function automatic logic [1:0] last_of(input logic [2:0] c);
        return c[2] ? c[1:0] + 2'd1 : c[1:0];
    endfunction

    // Model of one clock edge, written from the requirements.
    task automatic model_edge();
        if (stb) begin
            m_code = code; m_valid = 1'b1; m_done = 1'b0; m_err = (code == 3'b111);
            m_prof = chained(code) ? 2'd0 : ext;
            m_addr = st[m_prof];
        end else if (en && m_valid) begin
            if (chained(m_code)) begin
                if (m_addr != fn[m_prof]) m_addr = m_addr + 1'b1;
                else if (m_prof != last_of(m_code)) begin
                    m_prof = m_prof + 2'd1; m_addr = st[m_prof];
                end else if (m_code[2]) begin
                    m_prof = 2'd0; m_addr = st[0];
                end else begin
                    m_valid = 1'b0; m_done = 1'b1;
                end
            end else begin
                if (ext != m_prof) begin
                    m_prof = ext; m_addr = st[ext];
                end else if (m_addr != fn[m_prof]) m_addr = m_addr + 1'b1;
                else if (rc[m_prof]) m_addr = st[m_prof];
            end
        end
    endtask

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "prof_idx", int'(prof_idx), int'(m_prof));
        chk(tag, "ram_addr", int'(ram_addr), int'(m_addr));
        chk(tag, "addr_valid", int'(addr_valid), int'(m_valid));
        chk(tag, "burst_done", int'(burst_done), int'(m_done));
        chk(tag, "code_err", int'(code_err), int'(m_err));
    endtask

    // One cycle: inputs already driven at negedge; update model at the edge, compare at next negedge.
    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
        stb = 1'b0;
    endtask

    task automatic strobe(input logic [2:0] c, input string tag);
        code = c; stb = 1'b1;
        step(tag);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic finish_up();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        void'($urandom(32'd7351));
        st[0] = 10'd10;  fn[0] = 10'd12;
        st[1] = 10'd20;  fn[1] = 10'd20;
        st[2] = 10'd30;  fn[2] = 10'd31;
        st[3] = 10'd40;  fn[3] = 10'd42;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle after reset, enable alone does nothing
        en = 1'b1;
        run(3, "R1");
        // R2: chained strobe loads profile 0
        strobe(3'b010, "R2");
        chk("R2", "start addr", int'(ram_addr), 10);
        // R3: stepping with the enable toggling
        en = 1'b0; run(2, "R3");
        en = 1'b1; run(2, "R3");
        // R4: one-address profile 1, then profile 2
        run(2, "R4");
        chk("R4", "profile after zero-length seg", int'(prof_idx), 2);
        // R5: burst ends after profile 2 and holds
        run(4, "R5");
        chk("R5", "done", int'(burst_done), 1);
        chk("R5", "hold addr", int'(ram_addr), 31);
        // R11: restart after done
        strobe(3'b011, "R11");
        chk("R11", "done cleared", int'(burst_done), 0);
        // R7: recirculate bits set but ignored in chained mode
        rc = 4'b1111;
        run(14, "R7");
        chk("R7", "burst through 3", int'(burst_done), 1);
        strobe(3'b001, "R5");
        run(8, "R5");
        // R6: continuous loops
        rc = 4'b0000;
        strobe(3'b101, "R6");
        run(30, "R6");
        chk("R6", "never done", int'(burst_done), 0);
        strobe(3'b110, "R6");
        run(20, "R6");
        strobe(3'b100, "R6");
        run(12, "R6");
        // R10: strobe mid-sweep with enable low
        en = 1'b0;
        strobe(3'b011, "R10");
        chk("R10", "restart prof", int'(prof_idx), 0);
        en = 1'b1; run(3, "R10");
        // R8: manual mode
        ext = 2'd2; rc[2] = 1'b0;
        strobe(3'b000, "R8");
        chk("R8", "ext profile", int'(prof_idx), 2);
        run(4, "R8");
        rc[2] = 1'b1; run(4, "R8");
        ext = 2'd3; run(5, "R8");
        // R9: invalid code acts as manual and flags error
        ext = 2'd1;
        strobe(3'b111, "R9");
        chk("R9", "err", int'(code_err), 1);
        run(3, "R9");
        strobe(3'b010, "R9");
        chk("R9", "err cleared", int'(code_err), 0);
        // Random phase
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 99) < 4) begin
                for (int p = 0; p < 4; p++) begin
                    st[p] = 10'($urandom_range(0, 1000));
                    fn[p] = st[p] + 10'($urandom_range(0, 4));
                end
                rc = 4'($urandom);
            end
            en = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 99) < 8) ext = 2'($urandom);
            if ($urandom_range(0, 99) < 3) begin
                code = 3'($urandom); stb = 1'b1;
            end
            step("R3");
        end
        finish_up();
    end

endmodule